// File: doc/BRIEF.md
# Interrupt source routing controller

This block is the source stage of a two-level interrupt controller. It holds a table of edge-style, message-like interrupt sources. For each source it stores the server that should receive the source, its current priority and a saved priority. It also keeps three flags: an event held while masked, an event waiting to be presented, and a reject mark. The priority value 0xFF doubles as the mask. When an enabled source fires, the block sends a presentation to the per-server presentation stage. A presentation carries the global source number (the local index plus a fixed base), the priority and the server.

The presentation stage can hand a source back with a reject strobe, and it can later ask for a resend. A resend starts a walk over the table, one entry per cycle, that presents again every rejected source that is not masked. Events that arrive while a source is masked are held and presented as soon as a configuration operation unmasks the source. A configuration port reads and writes the server and priority of each source. It can also mask a source while saving its priority, and later restore that saved priority. Each operation answers with a status code.

Only one presentation leaves per cycle. Configuration-triggered presentations win over fired events, and fired events win over the resend walk. The losers wait: fired events stay pending and the walk stalls on its current entry.

Top module: `isr_route_ctrl`

## Requirements
- R1: After reset every source has server 0, priority 0xFF and saved priority 0xFF, with no flags set. No presentation is driven, `resend_busy_o` is 0 and no acknowledge is driven.
- R2: A fire pulse on an unmasked source (priority below 0xFF) produces a one-cycle presentation in the next cycle. It carries number SRC_BASE + index, the stored priority and the stored server.
- R3: A fire pulse on a masked source presents nothing and holds the event. A later configuration write with a priority other than 0xFF presents the source in the acknowledge cycle, using the new server and priority. A write of 0xFF keeps the event held.
- R4: `cfg_op_i` = 1 writes server and priority. It returns status 0x00, or 0xFD (-3) with no state change when the number is outside [SRC_BASE, SRC_BASE+NUM_SRC), the server is not below NUM_SRV, or the priority exceeds 0xFF. Each request is acknowledged exactly one cycle later.
- R5: `cfg_op_i` = 0 reads a source. For a valid number it returns status 0x00 with the stored server and priority. For an invalid number it returns 0xFD.
- R6: A reject strobe marks its source. A resend request presents each marked, unmasked source once, and the presentation clears the mark, so a second resend presents nothing.
- R7: A marked source whose priority is 0xFF is skipped by the walk and keeps its mark. If it is later unmasked, the next resend presents it.
- R8: `resend_busy_o` rises the cycle after a resend request. With nothing competing, entry i is handled in the i-th cycle that follows, and the flag drops after NUM_SRC cycles. A resend request during a walk restarts it at entry 0.
- R9: In one cycle, a configuration presentation goes before a fired event, and a fired event goes before the walk. A losing fired event is presented in the next free cycle, and a stalled walk resumes at the same entry.
- R10: Several sources firing together are presented one per cycle in ascending index order.
- R11: `cfg_op_i` = 2 saves the priority and masks the source. `cfg_op_i` = 3 restores the saved priority and presents an event held during the masked period. Both return 0xFD for an invalid number.
- R12: A reject strobe with a number outside the valid range changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fire_i | input | NUM_SRC | One-cycle event pulse per source |
| reject_i | input | 1 | Reject strobe from the presentation stage |
| reject_num_i | input | NUM_W | Global number being rejected |
| resend_i | input | 1 | Resend request, starts or restarts the walk |
| cfg_req_i | input | 1 | Configuration request strobe |
| cfg_op_i | input | 2 | 0 read, 1 write, 2 mask with save, 3 restore |
| cfg_num_i | input | NUM_W | Global source number |
| cfg_server_i | input | ARG_W | Server argument of a write |
| cfg_prio_i | input | ARG_W | Priority argument of a write |
| cfg_ack_o | output | 1 | Acknowledge, one cycle after a request |
| cfg_status_o | output | 8 | 0x00 success, 0xFD invalid argument |
| cfg_server_o | output | SW | Server returned by a read |
| cfg_prio_o | output | 8 | Priority returned by a read |
| pres_valid_o | output | 1 | Presentation valid for one cycle |
| pres_server_o | output | SW | Target server |
| pres_num_o | output | NUM_W | Global source number |
| pres_prio_o | output | 8 | Priority of the presented source |
| resend_busy_o | output | 1 | Resend walk in progress |

## Verification
All outputs are registered. The acknowledge, the read data and any presentation that a configuration operation triggers appear in the cycle after the request edge. A fired event appears in the cycle after its pulse, or later by one cycle for each presentation that wins over it. After a resend request, entry i is handled i+1 cycles after the busy flag rises. The driver stamps every expected presentation with the cycle it is due in, and the monitor compares both the contents and that cycle. Any presentation that arrives early, late or unannounced therefore fails, and so does a missing one. Busy flag timing is sampled on the exact first and last cycles the requirements predict.

// File: rtl/isr_pkg.sv
package isr_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_MASK    = 2'd2,
        OP_RESTORE = 2'd3
    } cfg_op_e;

    localparam logic [7:0] PRIO_MASKED = 8'hFF;
    localparam logic [7:0] ST_OK       = 8'h00;
    localparam logic [7:0] ST_BAD_ARG  = 8'hFD;

endpackage

// File: rtl/isr_num_decode.sv
module isr_num_decode #(
    parameter int NUM_W    = 16,
    parameter int NUM_SRC  = 8,
    parameter int SRC_BASE = 32,
    parameter int IW       = 3
) (
    input  logic [NUM_W-1:0] num_i,
    output logic             hit_o,
    output logic [IW-1:0]    idx_o
);
    localparam logic [NUM_W:0] LO = (NUM_W+1)'(SRC_BASE);
    localparam logic [NUM_W:0] HI = (NUM_W+1)'(SRC_BASE + NUM_SRC);

    logic [NUM_W:0] wide;

    assign wide  = {1'b0, num_i};
    assign hit_o = (wide >= LO) && (wide < HI);
    // difference is below NUM_SRC whenever hit_o is set, so IW bits suffice
    assign idx_o = num_i[IW-1:0] - LO[IW-1:0];
endmodule

// File: rtl/isr_arg_check.sv
module isr_arg_check #(
    parameter int ARG_W   = 16,
    parameter int NUM_SRV = 4
) (
    input  logic [ARG_W-1:0] server_i,
    input  logic [ARG_W-1:0] prio_i,
    output logic             ok_o
);
    localparam logic [ARG_W-1:0] SRV_LIM  = ARG_W'(NUM_SRV);
    localparam logic [ARG_W-1:0] PRIO_MAX = ARG_W'(255);

    assign ok_o = (server_i < SRV_LIM) && (prio_i <= PRIO_MAX);
endmodule

// File: rtl/isr_pick_first.sv
module isr_pick_first #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/isr_route_ctrl.sv
module isr_route_ctrl
    import isr_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_SRV  = 4,
    parameter int SRC_BASE = 32,
    parameter int NUM_W    = 16,
    parameter int ARG_W    = 16,
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int SW = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] fire_i,
    input  logic               reject_i,
    input  logic [NUM_W-1:0]   reject_num_i,
    input  logic               resend_i,
    input  logic               cfg_req_i,
    input  logic [1:0]         cfg_op_i,
    input  logic [NUM_W-1:0]   cfg_num_i,
    input  logic [ARG_W-1:0]   cfg_server_i,
    input  logic [ARG_W-1:0]   cfg_prio_i,
    output logic               cfg_ack_o,
    output logic [7:0]         cfg_status_o,
    output logic [SW-1:0]      cfg_server_o,
    output logic [7:0]         cfg_prio_o,
    output logic               pres_valid_o,
    output logic [SW-1:0]      pres_server_o,
    output logic [NUM_W-1:0]   pres_num_o,
    output logic [7:0]         pres_prio_o,
    output logic               resend_busy_o
);
    localparam logic [IW-1:0]    LAST_IDX = IW'(NUM_SRC - 1);
    localparam logic [NUM_W-1:0] BASE_NUM = NUM_W'(SRC_BASE);

    typedef struct packed {
        logic [NUM_SRC-1:0][SW-1:0] server;
        logic [NUM_SRC-1:0][7:0]    prio;
        logic [NUM_SRC-1:0][7:0]    saved;
        logic [NUM_SRC-1:0]         held;     // event seen while masked
        logic [NUM_SRC-1:0]         waiting;  // unmasked event not yet sent
        logic [NUM_SRC-1:0]         marked;   // rejected by presentation stage
        logic                       busy;
        logic [IW-1:0]              widx;
        logic                       pv;
        logic [SW-1:0]              psrv;
        logic [NUM_W-1:0]           pnum;
        logic [7:0]                 pprio;
        logic                       ack;
        logic [7:0]                 status;
        logic [SW-1:0]              rsrv;
        logic [7:0]                 rprio;
    } state_t;

    state_t s_q, s_d;

    // ------------------------------------------------------------------
    // decoders and argument checks (depend on inputs only)
    // ------------------------------------------------------------------
    logic          cfg_hit, rej_hit, args_ok;
    logic [IW-1:0] cfg_idx, rej_idx;

    isr_num_decode #(
        .NUM_W(NUM_W), .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .IW(IW)
    ) i_cfg_dec (
        .num_i(cfg_num_i), .hit_o(cfg_hit), .idx_o(cfg_idx)
    );

    isr_num_decode #(
        .NUM_W(NUM_W), .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .IW(IW)
    ) i_rej_dec (
        .num_i(reject_num_i), .hit_o(rej_hit), .idx_o(rej_idx)
    );

    isr_arg_check #(
        .ARG_W(ARG_W), .NUM_SRV(NUM_SRV)
    ) i_arg_chk (
        .server_i(cfg_server_i), .prio_i(cfg_prio_i), .ok_o(args_ok)
    );

    // ------------------------------------------------------------------
    // fire candidates: entries the config port touches this cycle wait
    // ------------------------------------------------------------------
    logic [NUM_SRC-1:0] masked_q, cfg_touch, fire_cand;
    logic               f_found;
    logic [IW-1:0]      f_idx;

    always_comb begin
        cfg_touch = '0;
        if (cfg_req_i && cfg_hit && (cfg_op_e'(cfg_op_i) != OP_READ)) begin
            cfg_touch[cfg_idx] = 1'b1;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            masked_q[i] = (s_q.prio[i] == PRIO_MASKED);
        end
        fire_cand = (s_q.waiting | (fire_i & ~masked_q)) & ~cfg_touch;
    end

    isr_pick_first #(
        .N(NUM_SRC), .IW(IW)
    ) i_fire_pick (
        .req_i(fire_cand), .found_o(f_found), .idx_o(f_idx)
    );

    function automatic state_t present_one(state_t s, logic [IW-1:0] i);
        state_t r;
        r            = s;
        r.pv         = 1'b1;
        r.psrv       = s.server[i];
        r.pnum       = BASE_NUM + {{(NUM_W-IW){1'b0}}, i};
        r.pprio      = s.prio[i];
        r.marked[i]  = 1'b0;
        r.waiting[i] = 1'b0;
        return r;
    endfunction

    // ------------------------------------------------------------------
    // next state
    // ------------------------------------------------------------------
    logic       upd, cfg_pres, fire_pres, walk_hit;
    logic [7:0] new_prio;

    always_comb begin
        s_d       = s_q;
        s_d.pv    = 1'b0;
        s_d.ack   = 1'b0;
        upd       = 1'b0;
        cfg_pres  = 1'b0;
        fire_pres = 1'b0;
        walk_hit  = 1'b0;
        new_prio  = PRIO_MASKED;

        // latch incoming events
        for (int i = 0; i < NUM_SRC; i++) begin
            if (fire_i[i]) begin
                if (masked_q[i]) s_d.held[i]    = 1'b1;
                else             s_d.waiting[i] = 1'b1;
            end
        end

        // configuration port
        if (cfg_req_i) begin
            s_d.ack    = 1'b1;
            s_d.status = ST_BAD_ARG;
            unique case (cfg_op_e'(cfg_op_i))
                OP_READ: begin
                    if (cfg_hit) begin
                        s_d.status = ST_OK;
                        s_d.rsrv   = s_q.server[cfg_idx];
                        s_d.rprio  = s_q.prio[cfg_idx];
                    end
                end
                OP_WRITE: begin
                    if (cfg_hit && args_ok) begin
                        s_d.status          = ST_OK;
                        s_d.server[cfg_idx] = cfg_server_i[SW-1:0];
                        upd                 = 1'b1;
                        new_prio            = cfg_prio_i[7:0];
                    end
                end
                OP_MASK: begin
                    if (cfg_hit) begin
                        s_d.status         = ST_OK;
                        s_d.saved[cfg_idx] = s_q.prio[cfg_idx];
                        upd                = 1'b1;
                        new_prio           = PRIO_MASKED;
                    end
                end
                OP_RESTORE: begin
                    if (cfg_hit) begin
                        s_d.status = ST_OK;
                        upd        = 1'b1;
                        new_prio   = s_q.saved[cfg_idx];
                    end
                end
                default: ;
            endcase
        end

        if (upd) begin
            s_d.prio[cfg_idx] = new_prio;
            if (new_prio == PRIO_MASKED) begin
                if (s_d.waiting[cfg_idx]) begin
                    s_d.waiting[cfg_idx] = 1'b0;
                    s_d.held[cfg_idx]    = 1'b1;
                end
            end else if (s_d.held[cfg_idx]) begin
                s_d.held[cfg_idx] = 1'b0;
                cfg_pres          = 1'b1;
            end
        end

        // presentation: config first, then fired events
        if (cfg_pres) begin
            s_d = present_one(s_d, cfg_idx);
        end else if (f_found) begin
            s_d       = present_one(s_d, f_idx);
            fire_pres = 1'b1;
        end

        // resend walk, lowest priority of the three
        if (resend_i) begin
            s_d.busy = 1'b1;
            s_d.widx = '0;
        end else if (s_q.busy) begin
            walk_hit = s_d.marked[s_q.widx] && (s_d.prio[s_q.widx] != PRIO_MASKED);
            if (!(walk_hit && (cfg_pres || fire_pres))) begin
                if (walk_hit) begin
                    s_d = present_one(s_d, s_q.widx);
                end
                if (s_q.widx == LAST_IDX) s_d.busy = 1'b0;
                else                      s_d.widx = s_q.widx + 1'b1;
            end
        end

        // reject strobe marks after any clear of this cycle
        if (reject_i && rej_hit) begin
            s_d.marked[rej_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.prio  <= '1;
            s_q.saved <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_ack_o     = s_q.ack;
    assign cfg_status_o  = s_q.status;
    assign cfg_server_o  = s_q.rsrv;
    assign cfg_prio_o    = s_q.rprio;
    assign pres_valid_o  = s_q.pv;
    assign pres_server_o = s_q.psrv;
    assign pres_num_o    = s_q.pnum;
    assign pres_prio_o   = s_q.pprio;
    assign resend_busy_o = s_q.busy;

endmodule

// File: rtl/isr_route_ctrl_chk.sv
module isr_route_ctrl_chk #(
    parameter int NUM_SRC  = 8,
    parameter int NUM_SRV  = 4,
    parameter int SRC_BASE = 32,
    parameter int NUM_W    = 16,
    localparam int SW = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cfg_req_i,
    input logic             resend_i,
    input logic             cfg_ack_o,
    input logic [7:0]       cfg_status_o,
    input logic             pres_valid_o,
    input logic [SW-1:0]    pres_server_o,
    input logic [NUM_W-1:0] pres_num_o,
    input logic [7:0]       pres_prio_o,
    input logic             resend_busy_o
);
    a_r3_masked_never_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pres_valid_o |-> (pres_prio_o != 8'hFF));

    a_r2_number_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pres_valid_o |-> ((int'(pres_num_o) >= SRC_BASE) &&
                          (int'(pres_num_o) < SRC_BASE + NUM_SRC)));

    a_r2_server_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pres_valid_o |-> (int'(pres_server_o) < NUM_SRV));

    a_r4_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_req_i |=> cfg_ack_o);

    a_r4_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_req_i |=> !cfg_ack_o);

    a_r4_status_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_ack_o |-> ((cfg_status_o == 8'h00) || (cfg_status_o == 8'hFD)));

    a_r8_busy_after_resend: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resend_i |=> resend_busy_o);
endmodule

bind isr_route_ctrl isr_route_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .SRC_BASE(SRC_BASE), .NUM_W(NUM_W)
) i_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_req_i(cfg_req_i), .resend_i(resend_i),
    .cfg_ack_o(cfg_ack_o), .cfg_status_o(cfg_status_o),
    .pres_valid_o(pres_valid_o), .pres_server_o(pres_server_o),
    .pres_num_o(pres_num_o), .pres_prio_o(pres_prio_o),
    .resend_busy_o(resend_busy_o)
);

// File: tb/test_isr_route_ctrl.sv
module test_isr_route_ctrl;
    localparam int N = 8, NSRV = 4, BASE = 32, NW = 16, AW = 16, SW = 2;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0]  fire_i = '0;
    logic          reject_i = 1'b0, resend_i = 1'b0, cfg_req_i = 1'b0;
    logic [NW-1:0] reject_num_i = '0, cfg_num_i = '0;
    logic [1:0]    cfg_op_i = '0;
    logic [AW-1:0] cfg_server_i = '0, cfg_prio_i = '0;
    logic          cfg_ack_o, pres_valid_o, resend_busy_o;
    logic [7:0]    cfg_status_o, cfg_prio_o, pres_prio_o;
    logic [SW-1:0] cfg_server_o, pres_server_o;
    logic [NW-1:0] pres_num_o;

    isr_route_ctrl #(.NUM_SRC(N), .NUM_SRV(NSRV), .SRC_BASE(BASE),
                     .NUM_W(NW), .ARG_W(AW)) i_isr_route_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .fire_i(fire_i), .reject_i(reject_i),
        .reject_num_i(reject_num_i), .resend_i(resend_i), .cfg_req_i(cfg_req_i),
        .cfg_op_i(cfg_op_i), .cfg_num_i(cfg_num_i), .cfg_server_i(cfg_server_i),
        .cfg_prio_i(cfg_prio_i), .cfg_ack_o(cfg_ack_o), .cfg_status_o(cfg_status_o),
        .cfg_server_o(cfg_server_o), .cfg_prio_o(cfg_prio_o),
        .pres_valid_o(pres_valid_o), .pres_server_o(pres_server_o),
        .pres_num_o(pres_num_o), .pres_prio_o(pres_prio_o),
        .resend_busy_o(resend_busy_o)
    );

    always #2 clk = ~clk;  // 250 MHz

    int cyc = 0, checks = 0, errors = 0;
    bit done = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int due; int num; int prio; int srv; string tag; } exp_t;
    exp_t q[$];

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_pres(input int due, input int num, input int prio,
                               input int srv, input string tag);
        exp_t e;
        e.due = due; e.num = num; e.prio = prio; e.srv = srv; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: every presentation must match the head item in its due cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (q.size() > 0 && q[0].due < cyc) begin
                checks++; errors++;
                $display("FAIL %s missing presentation actual=none expected=%0d", q[0].tag, q[0].num);
                void'(q.pop_front());
            end
            if (pres_valid_o) begin
                if (q.size() == 0 || q[0].due != cyc) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected presentation actual=%0d expected=none", pres_num_o);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.tag, "pres number", int'(pres_num_o), e.num);
                    check(e.tag, "pres prio", int'(pres_prio_o), e.prio);
                    check(e.tag, "pres server", int'(pres_server_o), e.srv);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cfg(input int op, input int num, input int srv, input int prio,
                          input int est, input bit rd, input int esrv, input int eprio,
                          input bit ep, input string tag);
        @(negedge clk);
        cfg_req_i = 1'b1; cfg_op_i = 2'(op); cfg_num_i = NW'(num);
        cfg_server_i = AW'(srv); cfg_prio_i = AW'(prio);
        if (ep) expect_pres(cyc + 1, num, prio, srv, tag);
        @(negedge clk);
        cfg_req_i = 1'b0;
        check(tag, "ack", int'(cfg_ack_o), 1);
        check(tag, "status", int'(cfg_status_o), est);
        if (rd) begin
            check(tag, "read server", int'(cfg_server_o), esrv);
            check(tag, "read prio", int'(cfg_prio_o), eprio);
        end
    endtask

    task automatic do_fire(input logic [N-1:0] m);
        @(negedge clk); fire_i = m;
        @(negedge clk); fire_i = '0;
    endtask

    task automatic do_reject(input int num);
        @(negedge clk); reject_i = 1'b1; reject_num_i = NW'(num);
        @(negedge clk); reject_i = 1'b0;
    endtask

    task automatic do_resend();
        @(negedge clk); resend_i = 1'b1;
        @(negedge clk); resend_i = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        int c;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1", "pres_valid", int'(pres_valid_o), 0);
        check("R1", "busy", int'(resend_busy_o), 0);
        check("R1", "ack", int'(cfg_ack_o), 0);
        do_cfg(0, 32, 0, 0, 8'h00, 1, 0, 8'hFF, 0, "R1");
        // R5 invalid reads
        do_cfg(0, 40, 0, 0, 8'hFD, 0, 0, 0, 0, "R5");
        do_cfg(0, 31, 0, 0, 8'hFD, 0, 0, 0, 0, "R5");

        // R3 masked event held, replayed on unmasking write
        do_fire(8'b0000_0100);
        idle(2);
        do_cfg(1, 34, 1, 5, 8'h00, 0, 0, 0, 1, "R3");
        do_cfg(0, 34, 0, 0, 8'h00, 1, 1, 5, 0, "R5");
        // R2 plain fire
        expect_pres(cyc + 2, 34, 5, 1, "R2");
        do_fire(8'b0000_0100);
        // R3 write of 0xFF keeps the event held
        do_fire(8'b0000_1000);
        do_cfg(1, 35, 2, 8'hFF, 8'h00, 0, 0, 0, 0, "R3");
        idle(2);
        do_cfg(1, 35, 2, 6, 8'h00, 0, 0, 0, 1, "R3");

        // R4 rejected writes leave state alone
        do_cfg(1, 40, 0, 1, 8'hFD, 0, 0, 0, 0, "R4");
        do_cfg(1, 34, 4, 1, 8'hFD, 0, 0, 0, 0, "R4");
        do_cfg(1, 34, 0, 16'h100, 8'hFD, 0, 0, 0, 0, "R4");
        do_cfg(0, 34, 0, 0, 8'h00, 1, 1, 5, 0, "R4");

        // R10 simultaneous fires, ascending order
        do_cfg(1, 32, 2, 3, 8'h00, 0, 0, 0, 0, "R10");
        do_cfg(1, 37, 3, 7, 8'h00, 0, 0, 0, 0, "R10");
        expect_pres(cyc + 2, 32, 3, 2, "R10");
        expect_pres(cyc + 3, 34, 5, 1, "R10");
        expect_pres(cyc + 4, 37, 7, 3, "R10");
        do_fire(8'b0010_0101);
        idle(3);

        // R9 config presentation beats a fire in the same cycle
        do_fire(8'b1000_0000);
        @(negedge clk);
        cfg_req_i = 1'b1; cfg_op_i = 2'd1; cfg_num_i = NW'(39);
        cfg_server_i = 0; cfg_prio_i = 9; fire_i = 8'b0000_0001;
        expect_pres(cyc + 1, 39, 9, 0, "R9");
        expect_pres(cyc + 2, 32, 3, 2, "R9");
        @(negedge clk);
        cfg_req_i = 1'b0; fire_i = '0;
        check("R9", "status", int'(cfg_status_o), 8'h00);
        idle(2);

        // R6 R7 R12 rejects and resend
        do_cfg(1, 33, 1, 4, 8'h00, 0, 0, 0, 0, "R12");
        do_reject(34);
        do_reject(37);
        do_reject(32);
        do_reject(41);   // R12 out of range (low bits select entry 1)
        do_reject(31);   // R12 out of range
        do_cfg(1, 32, 2, 8'hFF, 8'h00, 0, 0, 0, 0, "R7");
        c = cyc;
        expect_pres(c + 5, 34, 5, 1, "R6");
        expect_pres(c + 8, 37, 7, 3, "R6");
        do_resend();
        check("R8", "busy first cycle", int'(resend_busy_o), 1);
        wait_until(c + 9);
        check("R8", "busy last cycle", int'(resend_busy_o), 1);
        idle(1);
        check("R8", "busy dropped", int'(resend_busy_o), 0);
        do_resend();     // R6 marks cleared: nothing expected
        idle(12);

        // R8 restart during a walk
        do_reject(34);
        do_reject(37);
        c = cyc;
        expect_pres(c + 7, 34, 5, 1, "R8");
        expect_pres(c + 10, 37, 7, 3, "R8");
        @(negedge clk); resend_i = 1'b1;
        @(negedge clk); resend_i = 1'b0;
        @(negedge clk); resend_i = 1'b1;
        @(negedge clk); resend_i = 1'b0;
        wait_until(c + 11);
        check("R8", "busy before end", int'(resend_busy_o), 1);
        idle(1);
        check("R8", "busy after restart end", int'(resend_busy_o), 0);
        idle(2);

        // R7 unmasked marked source replays; R9 fire stalls the walk
        do_cfg(1, 32, 2, 3, 8'h00, 0, 0, 0, 0, "R7");
        do_reject(37);
        c = cyc;
        expect_pres(c + 3, 32, 3, 2, "R7");
        expect_pres(c + 8, 32, 3, 2, "R9");
        expect_pres(c + 9, 37, 7, 3, "R9");
        do_resend();
        wait_until(c + 7);
        fire_i = 8'b0000_0001;
        @(negedge clk); fire_i = '0;
        idle(10);

        // R11 mask with save, restore
        do_cfg(2, 34, 0, 0, 8'h00, 0, 0, 0, 0, "R11");
        do_cfg(0, 34, 0, 0, 8'h00, 1, 1, 8'hFF, 0, "R11");
        do_fire(8'b0000_0100);
        idle(2);
        @(negedge clk);
        cfg_req_i = 1'b1; cfg_op_i = 2'd3; cfg_num_i = NW'(34);
        expect_pres(cyc + 1, 34, 5, 1, "R11");
        @(negedge clk);
        cfg_req_i = 1'b0;
        check("R11", "restore status", int'(cfg_status_o), 8'h00);
        do_cfg(0, 34, 0, 0, 8'h00, 1, 1, 5, 0, "R11");
        do_cfg(2, 40, 0, 0, 8'hFD, 0, 0, 0, 0, "R11");
        do_cfg(3, 30, 0, 0, 8'hFD, 0, 0, 0, 0, "R11");
        idle(4);

        check("R2", "queue left", q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule